// File: doc/BRIEF.md
# Floppy Controller Command Sequencer

This block is the command, execution and result engine of a PC-style floppy disk controller for a single drive. The host sees two byte-wide registers: a main status register at offset 4, and a data FIFO at offset 5. Command bytes go into the FIFO while the status register shows the controller ready to receive. Result bytes are read back from the FIFO one at a time while the status register shows the controller ready to send.

Four commands are decoded: absolute seek, relative seek (inward or outward), sense interrupt and read ID. The block keeps the present cylinder number and the last selected head. It raises an interrupt when a seek completes and when a read ID enters its result phase. Read ID passes through an execution phase of a parameterised number of clock cycles, which stands in for the time a sector header takes to reach the head. Sector data transfer, DMA and drive electronics are not part of the block. Only one drive exists, so the drive-select bits of the command are not used.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset the status register reads 0x80 and irq is low. The first sense interrupt returns the single byte 0x80.
- R2: The status register reads 0x80 when the controller is idle and waiting for an opcode. It reads 0x90 once the first byte of a multi-byte command has been taken, 0x10 during execution and 0xD0 during the result phase. Bit 7 means ready, bit 6 means controller-to-host, bit 4 means busy, and bit 5 (non-DMA) always reads 0.
- R3: The following accesses are ignored and change no state:
  - writes to offsets other than 5;
  - writes to offset 5 outside the command phase;
  - reads of offset 5 outside the result phase, which also return 0x00.
- R4: Seek (0x0F) takes three bytes: the opcode, a select byte whose bit 2 is the head, and the target cylinder. The target cylinder becomes the present cylinder. irq stays unchanged while the opcode and the select byte are taken, and goes high the cycle after the third byte.
- R5: Relative seek inward (0xCF) adds its third byte to the present cylinder and saturates at 255. Relative seek outward (0x8F) subtracts its third byte and saturates at 0. Both raise irq, as in R4.
- R6: A sense interrupt (0x08) while an interrupt is pending returns two bytes. The first is ST0 = 0x20 | (head<<2) and the second is the present cylinder. irq falls the cycle after the opcode is taken.
- R7: A sense interrupt with no interrupt pending returns the single byte 0x80.
- R8: Read ID (0x0A, then a select byte) holds the status register at 0x10 for exactly RID_CYCLES cycles. It then returns seven bytes in this order: head<<2, 0x00, 0x00, present cylinder, head, 0x01, 0x02.
- R9: irq is high when the read ID result phase begins and stays high through the first six result bytes. It falls after the seventh byte is read, and the status register then reads 0x80.
- R10: Any other opcode returns the single byte 0x80, leaves irq unchanged, and returns the block to the command phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register offset (4 = status, 5 = data FIFO) |
| rd_stb | input | 1 | One-cycle read strobe; a FIFO read in the result phase consumes a byte |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected offset (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the embedded properties check the following:
- parameter bytes never move irq;
- the status register reads 0x10 throughout execution;
- the present cylinder changes only on a completed seek, and an inward step never lowers it;
- an accepted sense interrupt clears irq;
- the last read ID byte drops irq and returns the status register to idle;
- the execution timer starts from zero.

Only the bench scenarios can show the other behaviours:
- the contents and order of the result bytes;
- saturation at both cylinder limits;
- the exact length of the execution phase;
- that accesses out of phase are ignored.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

  localparam logic [2:0] OFS_STATUS = 3'd4;
  localparam logic [2:0] OFS_FIFO   = 3'd5;

  localparam logic [7:0] OPC_SENSE   = 8'h08;
  localparam logic [7:0] OPC_RDID    = 8'h0A;
  localparam logic [7:0] OPC_SEEK    = 8'h0F;
  localparam logic [7:0] OPC_STEPOUT = 8'h8F;
  localparam logic [7:0] OPC_STEPIN  = 8'hCF;

  localparam logic [7:0] ST_IDLE = 8'h80;
  localparam logic [7:0] ST_PARM = 8'h90;
  localparam logic [7:0] ST_EXEC = 8'h10;
  localparam logic [7:0] ST_RES  = 8'hD0;
  localparam logic [7:0] BYTE_INVALID = 8'h80;

  localparam int RES_DEPTH = 7;
  localparam int RES_LEN_W = $clog2(RES_DEPTH + 1);

  typedef enum logic [1:0] {PH_CMD, PH_EXEC, PH_RES} phase_e;
  typedef enum logic [2:0] {OP_SENSE, OP_SEEK, OP_STEPIN, OP_STEPOUT, OP_RDID, OP_BAD} op_e;

  // Relative step with clamping at both ends of the cylinder range.
  function automatic logic [7:0] step_cyl(input logic [7:0] cur, input logic [7:0] cnt,
                                          input logic inward);
    logic [8:0] sum;
    if (inward) begin
      sum = {1'b0, cur} + {1'b0, cnt};
      return sum[8] ? 8'hFF : sum[7:0];
    end
    return (cnt > cur) ? 8'h00 : cur - cnt;
  endfunction

  function automatic logic [7:0] st0_seek_end(input logic head);
    return {2'b00, 1'b1, 2'b00, head, 2'b00};
  endfunction

  function automatic logic [7:0] st0_normal(input logic head);
    return {5'b0, head, 2'b00};
  endfunction

endpackage

// File: rtl/fdc_opdec.sv
module fdc_opdec
  import fdc_seq_pkg::*;
(
  input  logic [7:0] opc,
  output op_e        op,
  output logic [1:0] nbytes
);
  always_comb begin
    case (opc)
      OPC_SENSE:   begin op = OP_SENSE;   nbytes = 2'd1; end
      OPC_SEEK:    begin op = OP_SEEK;    nbytes = 2'd3; end
      OPC_STEPIN:  begin op = OP_STEPIN;  nbytes = 2'd3; end
      OPC_STEPOUT: begin op = OP_STEPOUT; nbytes = 2'd3; end
      OPC_RDID:    begin op = OP_RDID;    nbytes = 2'd2; end
      default:     begin op = OP_BAD;     nbytes = 2'd1; end
    endcase
  end
endmodule

// File: rtl/fdc_exec_timer.sv
module fdc_exec_timer #(
  parameter int CYCLES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign done = run && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (done) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8
  timer_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run && cnt == '0));
endmodule

// File: rtl/fdc_res_buf.sv
module fdc_res_buf
  import fdc_seq_pkg::*;
#(
  parameter int DEPTH = RES_DEPTH,
  parameter int LW    = RES_LEN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LW-1:0]      load_len,
  input  logic [DEPTH*8-1:0] load_bytes,
  input  logic               pop,
  output logic [7:0]         cur,
  output logic               last
);
  logic [7:0]    mem [DEPTH];
  logic [LW-1:0] ptr;
  logic [LW-1:0] len;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mem[i] <= '0;
      else if (load) mem[i] <= load_bytes[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      len <= '0;
    end else if (load) begin
      ptr <= '0;
      len <= load_len;
    end else if (pop) begin
      ptr <= ptr + 1'b1;
    end
  end

  assign cur  = (ptr < LW'(DEPTH)) ? mem[ptr[$clog2(DEPTH)-1:0]] : 8'h00;
  assign last = (ptr == len - 1'b1);
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_seq_pkg::*;
#(
  parameter int RID_CYCLES = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_sel,
  input  logic       rd_stb,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq
);
  phase_e     phase;
  logic [1:0] idx;
  logic [7:0] opc_q;
  logic [7:0] pcn;
  logic       head_q;
  logic       pend;
  logic       rid_res;
  logic [7:0] msr;

  // Named events
  logic       fifo_sel, cmd_wr_acc, res_rd_acc, cmd_last;
  logic       sense_hit, seek_done, rid_start, exec_done;
  logic [7:0] opc_src;
  op_e        op;
  logic [1:0] need;

  logic                   ld;
  logic [RES_LEN_W-1:0]   ld_len;
  logic [RES_DEPTH*8-1:0] ld_bytes;
  logic [7:0]             res_cur;
  logic                   res_last;

  assign fifo_sel   = (reg_sel == OFS_FIFO);
  assign cmd_wr_acc = wr_stb && fifo_sel && (phase == PH_CMD);
  assign res_rd_acc = rd_stb && fifo_sel && (phase == PH_RES);
  assign opc_src    = (idx == 2'd0) ? wr_data : opc_q;

  fdc_opdec u_dec (.opc(opc_src), .op(op), .nbytes(need));

  assign cmd_last  = cmd_wr_acc && ((idx + 2'd1) == need);
  assign sense_hit = cmd_last && (op == OP_SENSE) && pend;
  assign seek_done = cmd_last && (op == OP_SEEK || op == OP_STEPIN || op == OP_STEPOUT);
  assign rid_start = cmd_last && (op == OP_RDID);

  fdc_exec_timer #(.CYCLES(RID_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(rid_start), .done(exec_done));

  always_comb begin
    ld       = 1'b0;
    ld_len   = '0;
    ld_bytes = '0;
    if (exec_done) begin
      ld       = 1'b1;
      ld_len   = RES_LEN_W'(7);
      ld_bytes[7:0]   = st0_normal(head_q);
      ld_bytes[31:24] = pcn;
      ld_bytes[39:32] = {7'b0, head_q};
      ld_bytes[47:40] = 8'h01;
      ld_bytes[55:48] = 8'h02;
    end else if (cmd_last && op == OP_SENSE) begin
      ld = 1'b1;
      if (pend) begin
        ld_len          = RES_LEN_W'(2);
        ld_bytes[7:0]   = st0_seek_end(head_q);
        ld_bytes[15:8]  = pcn;
      end else begin
        ld_len        = RES_LEN_W'(1);
        ld_bytes[7:0] = BYTE_INVALID;
      end
    end else if (cmd_last && op == OP_BAD) begin
      ld            = 1'b1;
      ld_len        = RES_LEN_W'(1);
      ld_bytes[7:0] = BYTE_INVALID;
    end
  end

  fdc_res_buf u_res (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_len(ld_len), .load_bytes(ld_bytes),
    .pop(res_rd_acc), .cur(res_cur), .last(res_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CMD;
      idx     <= 2'd0;
      opc_q   <= 8'h00;
      pcn     <= 8'h00;
      head_q  <= 1'b0;
      pend    <= 1'b0;
      rid_res <= 1'b0;
    end else begin
      if (cmd_wr_acc) begin
        if (idx == 2'd0) opc_q  <= wr_data;
        if (idx == 2'd1) head_q <= wr_data[2];
        if (cmd_last) begin
          idx <= 2'd0;
          case (op)
            OP_SENSE:   begin phase <= PH_RES; rid_res <= 1'b0; pend <= 1'b0; end
            OP_SEEK:    begin pcn <= wr_data; pend <= 1'b1; end
            OP_STEPIN:  begin pcn <= step_cyl(pcn, wr_data, 1'b1); pend <= 1'b1; end
            OP_STEPOUT: begin pcn <= step_cyl(pcn, wr_data, 1'b0); pend <= 1'b1; end
            OP_RDID:    phase <= PH_EXEC;
            default:    begin phase <= PH_RES; rid_res <= 1'b0; end
          endcase
        end else begin
          idx <= idx + 2'd1;
        end
      end
      if (exec_done) begin
        phase   <= PH_RES;
        pend    <= 1'b1;
        rid_res <= 1'b1;
      end
      if (res_rd_acc && res_last) begin
        phase <= PH_CMD;
        if (rid_res) pend <= 1'b0;
      end
    end
  end

  always_comb begin
    case (phase)
      PH_EXEC: msr = ST_EXEC;
      PH_RES:  msr = ST_RES;
      default: msr = (idx == 2'd0) ? ST_IDLE : ST_PARM;
    endcase
  end

  always_comb begin
    if (reg_sel == OFS_STATUS)              rd_data = msr;
    else if (fifo_sel && phase == PH_RES)   rd_data = res_cur;
    else                                    rd_data = 8'h00;
  end

  assign irq = pend;

  // R4
  param_irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_acc && !cmd_last) |=> $stable(irq));
  // R6
  sense_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sense_hit |=> !irq);
  // R9
  rid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd_acc && res_last && rid_res) |=> (!irq && rd_data != ST_RES && phase == PH_CMD));
  // R2
  exec_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC) |-> (msr == ST_EXEC));
  // R3
  pcn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seek_done |=> $stable(pcn));
  // R5
  step_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seek_done && op == OP_STEPIN) |=> (pcn >= $past(pcn)));
endmodule

// File: tb/sim_fdc_cmd_seq.sv
module sim_fdc_cmd_seq;
  localparam int RID = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic       rd_stb = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  int  bpcn = 0;
  bit  bhead = 0;
  bit  bpend = 0;

  fdc_cmd_seq #(.RID_CYCLES(RID)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] s, logic [7:0] d);
    @(negedge clk); reg_sel = s; wr_data = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic rd(logic [2:0] s, output logic [7:0] v);
    @(negedge clk); reg_sel = s; rd_stb = 1'b1;
    #1 v = rd_data;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic expect_b(string r, int v);
    exp_q.push_back(8'(v)); tag_q.push_back(r);
  endtask

  task automatic fifo_rd();
    logic [7:0] v;
    rd(3'd5, v);
    got_q.push_back(v);
  endtask

  task automatic status_is(string r, int e);
    logic [7:0] v;
    rd(3'd4, v);
    chk(r, v, e);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      wait (got_q.size() != 0);
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL unexpected byte actual=%0h expected=none", got_q.pop_front());
      end else begin
        chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
      end
    end
  end

  function automatic int model_step(int p, int c, bit inward);
    int r;
    r = inward ? p + c : p - c;
    if (r > 255) r = 255;
    if (r < 0) r = 0;
    return r;
  endfunction

  task automatic sense(string r);
    if (bpend) begin
      expect_b(r, 32 + (bhead ? 4 : 0));
      expect_b(r, bpcn);
    end else begin
      expect_b(r, 128);
    end
    wr(3'd5, 8'h08);
    repeat (bpend ? 2 : 1) fifo_rd();
    bpend = 0;
  endtask

  task automatic seek(bit h, int c);
    wr(3'd5, 8'h0F); wr(3'd5, {5'b0, h, 2'b0}); wr(3'd5, 8'(c));
    bpcn = c; bhead = h; bpend = 1;
  endtask

  task automatic step(bit inward, int c);
    wr(3'd5, inward ? 8'hCF : 8'h8F); wr(3'd5, {5'b0, bhead, 2'b0}); wr(3'd5, 8'(c));
    bpcn = model_step(bpcn, c, inward); bpend = 1;
  endtask

  task automatic read_id(bit h);
    int n;
    logic [7:0] v;
    wr(3'd5, 8'h0A);
    chk("R4 irq quiet after opcode", irq, 0);
    wr(3'd5, {5'b0, h, 2'b0});
    bhead = h;
    n = 0;
    #1 v = rd_data;
    reg_sel = 3'd4;
    #1 v = rd_data;
    while (v == 8'h10 && n < 1000) begin
      n++;
      @(negedge clk); #1 v = rd_data;
    end
    chk("R8 exec length", n, RID);
    chk("R2 result status", v, 8'hD0);
    chk("R9 irq at result", irq, 1);
    expect_b("R8 st0", h ? 4 : 0); expect_b("R8 st1", 0); expect_b("R8 st2", 0);
    expect_b("R8 cyl", bpcn); expect_b("R8 head", h);
    expect_b("R8 rec", 1); expect_b("R8 size", 2);
    for (int i = 0; i < 6; i++) begin
      fifo_rd();
      chk("R9 irq held", irq, 1);
    end
    fifo_rd();
    chk("R9 irq after last", irq, 0);
    status_is("R9 idle status", 8'h80);
    bpend = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    status_is("R1 reset status", 8'h80);
    chk("R1 reset irq", irq, 0);
    expect_b("R1 first sense", 128);
    wr(3'd5, 8'h08); fifo_rd();
    status_is("R7 back idle", 8'h80);

    // R3: other offsets and out-of-phase FIFO reads
    wr(3'd2, 8'h0F); wr(3'd7, 8'h0F);
    status_is("R3 stray writes", 8'h80);
    rd(3'd5, v);
    chk("R3 fifo read in cmd phase", v, 0);

    // R4 seek
    wr(3'd5, 8'h0F);
    status_is("R2 param status", 8'h90);
    chk("R4 irq after opcode", irq, 0);
    wr(3'd5, 8'h04);
    chk("R4 irq after select", irq, 0);
    wr(3'd5, 8'd5);
    chk("R4 irq after cylinder", irq, 1);
    bpcn = 5; bhead = 1; bpend = 1;
    status_is("R4 idle after seek", 8'h80);

    // R6 sense with pending, R3 write ignored in result phase
    expect_b("R6 st0", 8'h24); expect_b("R6 pcn", 5);
    wr(3'd5, 8'h08);
    chk("R6 irq cleared", irq, 0);
    status_is("R2 result status", 8'hD0);
    fifo_rd();
    wr(3'd5, 8'h0F);
    fifo_rd();
    bpend = 0;
    status_is("R3 write in result ignored", 8'h80);
    sense("R7 no pending");

    // R5 relative seeks
    bhead = 0;
    seek(0, 5);
    sense("R4 seek head0");
    step(1, 3); sense("R5 in by 3");
    step(0, 10); sense("R5 out clamp 0");
    seek(0, 200); sense("R4 seek 200");
    step(1, 100); sense("R5 in clamp 255");
    step(0, 55); sense("R5 out by 55");

    // R8/R9 read ID
    read_id(1);
    seek(0, 8); sense("R4 seek 8");
    read_id(0);

    // R10 invalid opcode
    expect_b("R10 invalid", 128);
    wr(3'd5, 8'h55); fifo_rd();
    chk("R10 irq unchanged low", irq, 0);
    status_is("R10 back to cmd", 8'h80);
    seek(1, 3);
    expect_b("R10 invalid pending", 128);
    wr(3'd5, 8'hA5); fifo_rd();
    chk("R10 irq unchanged high", irq, 1);
    sense("R10 pending kept");
    sense("R7 final");

    repeat (4) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule